// File: doc/BRIEF.md
# Memory Region Protection Rule Checker

This block sits in front of a DRAM controller and decides, one transaction per cycle, whether an access may proceed. Software fills a table of twenty rules through a small indirect register window. Each rule describes a window of memory in 1 MiB pages, a range of master IDs, the set of ports it applies to, and which security classes it covers, along with an accept or reject result. An incoming request carries the upper address bits, a master ID, a port number and a secure flag. The checker looks for the lowest-numbered valid rule that covers the request and returns that rule's verdict. When no rule covers the request, a per-port default mask decides.

Software edits rules in staging registers. A commit command copies the staged contents into one rule. A load command copies one rule back into the staging registers so software can read it. Staged edits have no effect on checking until a commit is issued.

Top module: `regionGuard`

## Requirements
- R1: After reset the verdict output is not valid, the command index, all staging registers and the default mask read as 0, and every rule is invalid, so any request is accepted with no hit.
- R2: Register select 0 is the command register. Bits [4:0] pick the rule, bit 5 commits the staging registers into that rule, and bit 6 loads that rule into the staging registers. If both bits are set, only the commit happens. An index of 20 or more never commits or loads.
- R3: Register select 1 holds the first page in bits [11:0] and the last page in bits [23:12]. A rule covers a request only when the request's byte address bits [31:20] lie between the two pages, both ends included.
- R4: Register select 2 holds the lowest master ID in bits [11:0] and the highest in bits [23:12]. A rule covers a request only when the request ID lies in that range, both ends included.
- R5: In register select 3, bits [12:3] are a port mask, and a rule covers only ports whose mask bit is 1. Bits [1:0] are a security field: bit 0 admits secure requests and bit 1 admits non-secure ones.
- R6: In register select 3, bit 2 marks the rule valid and bit 13 gives the result (0 accepts, 1 rejects). A rule written with all zeros never matches.
- R7: When several rules cover a request, the lowest-numbered one decides the verdict and is the rule reported.
- R8: Register select 4 is a 10-bit default mask used when no rule covers the request. Bit n set to 1 rejects requests on port n, and 0 accepts them. A port number of 10 or more is always rejected, with no hit.
- R9: A verdict appears in the cycle after its request handshake. While the verdict is valid and not taken, the verdict holds steady and reqReady is low. A no-hit verdict reports rule 0.
- R10: Writes to staging registers do not change checking until a commit. A request presented in the cycle right after a commit write already sees the committed rule.
- R11: After a load command, the address, ID and data staging registers read back the selected rule's stored contents, with unused bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regSel | input | 3 | Register select (0 command, 1 address, 2 ID, 3 data, 4 default) |
| regWdata | input | 24 | Register write data |
| regRdata | output | 24 | Read data of the selected register |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted this cycle |
| reqAddrHi | input | 12 | Byte address bits [31:20] |
| reqId | input | 12 | Master ID |
| reqPort | input | 4 | Port number |
| reqSecure | input | 1 | 1 marks a secure request |
| vdValid | output | 1 | Verdict present |
| vdReady | input | 1 | Verdict taken by the consumer |
| vdAccept | output | 1 | 1 means the access is allowed |
| vdHit | output | 1 | 1 means a rule decided the verdict |
| vdRule | output | 5 | Deciding rule number, 0 when there is no hit |

## Verification
A rule stored with a wrong field shows up on the next request that falls inside that field's boundary. The bench therefore places requests on both inclusive edges of every range and on one value just outside. A fault in priority or staging would return the wrong rule number or a hit that should not happen, one cycle after the request. The bench checks vdRule and vdHit, not just the accept bit. Load readback brings the stored table out through the register window, so a corrupted commit becomes visible even without any traffic.

// File: rtl/rgPkg.sv
package rgPkg;
  localparam int RG_RULES  = 20;
  localparam int RG_PORTS  = 10;
  localparam int RG_FIELD  = 12;
  localparam int RG_IDX_W  = $clog2(RG_RULES);
  localparam int RG_PORT_W = 4;
  localparam int RG_BUS_W  = 2 * RG_FIELD;

  typedef struct packed {
    logic                reject;
    logic [RG_PORTS-1:0] portMask;
    logic                valid;
    logic [1:0]          sec;
    logic [RG_FIELD-1:0] idHi;
    logic [RG_FIELD-1:0] idLo;
    logic [RG_FIELD-1:0] hiPage;
    logic [RG_FIELD-1:0] loPage;
  } rgRule_t;

  typedef struct packed {
    logic                commit;
    logic                load;
    logic [RG_IDX_W-1:0] idx;
  } rgStrobe_t;

  typedef enum logic [2:0] {
    SEL_CMD  = 3'd0,
    SEL_ADDR = 3'd1,
    SEL_ID   = 3'd2,
    SEL_DATA = 3'd3,
    SEL_DEF  = 3'd4
  } rgSel_e;
endpackage

// File: rtl/rgCtrl.sv
module rgCtrl
  import rgPkg::*;
#(
  parameter int NUM_RULES = RG_RULES
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWe,
  input  logic [2:0]          regSel,
  input  logic [RG_BUS_W-1:0] regWdata,
  output logic [RG_BUS_W-1:0] regRdata,
  input  rgRule_t             readRule,
  output rgStrobe_t           strobe,
  output rgRule_t             stage,
  output logic [RG_PORTS-1:0] defMask
);
  localparam int CMD_COMMIT = RG_IDX_W;
  localparam int CMD_LOAD   = RG_IDX_W + 1;

  logic [RG_IDX_W-1:0] cmdIdx;
  logic                cmdWrite;
  logic                idxLegal;
  logic [RG_IDX_W-1:0] wIdx;

  assign cmdWrite = regWe && (regSel == SEL_CMD);
  assign wIdx     = regWdata[RG_IDX_W-1:0];
  assign idxLegal = (32'(wIdx) < NUM_RULES);

  // Strobes are decoded directly from the command write; commit wins over load.
  always_comb begin
    strobe.idx    = wIdx;
    strobe.commit = cmdWrite && idxLegal && regWdata[CMD_COMMIT];
    strobe.load   = cmdWrite && idxLegal && regWdata[CMD_LOAD] && !regWdata[CMD_COMMIT];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdIdx  <= '0;
      stage   <= '0;
      defMask <= '0;
    end else begin
      if (cmdWrite) cmdIdx <= wIdx;
      if (strobe.load) begin
        stage <= readRule;
      end else if (regWe) begin
        unique case (regSel)
          SEL_ADDR: begin
            stage.loPage <= regWdata[RG_FIELD-1:0];
            stage.hiPage <= regWdata[2*RG_FIELD-1:RG_FIELD];
          end
          SEL_ID: begin
            stage.idLo <= regWdata[RG_FIELD-1:0];
            stage.idHi <= regWdata[2*RG_FIELD-1:RG_FIELD];
          end
          SEL_DATA: begin
            stage.sec      <= regWdata[1:0];
            stage.valid    <= regWdata[2];
            stage.portMask <= regWdata[RG_PORTS+2:3];
            stage.reject   <= regWdata[RG_PORTS+3];
          end
          SEL_DEF: defMask <= regWdata[RG_PORTS-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    regRdata = '0;
    unique case (regSel)
      SEL_CMD:  regRdata = RG_BUS_W'(cmdIdx);
      SEL_ADDR: regRdata = {stage.hiPage, stage.loPage};
      SEL_ID:   regRdata = {stage.idHi, stage.idLo};
      SEL_DATA: regRdata = RG_BUS_W'({stage.reject, stage.portMask, stage.valid, stage.sec});
      SEL_DEF:  regRdata = RG_BUS_W'(defMask);
      default:  regRdata = '0;
    endcase
  end

  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.commit, strobe.load})); // R2
  AST_STROBE_IDX_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit || strobe.load) |-> (32'(strobe.idx) < NUM_RULES)); // R2
  AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> stage == $past(readRule)); // R11
endmodule

// File: rtl/rgMatch.sv
module rgMatch
  import rgPkg::*;
#(
  parameter int NUM_RULES = RG_RULES
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rgStrobe_t            strobe,
  input  rgRule_t              stage,
  input  logic [RG_PORTS-1:0]  defMask,
  output rgRule_t              readRule,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic [RG_FIELD-1:0]  reqAddrHi,
  input  logic [RG_FIELD-1:0]  reqId,
  input  logic [RG_PORT_W-1:0] reqPort,
  input  logic                 reqSecure,
  output logic                 vdValid,
  input  logic                 vdReady,
  output logic                 vdAccept,
  output logic                 vdHit,
  output logic [RG_IDX_W-1:0]  vdRule
);
  rgRule_t             rules [NUM_RULES];
  logic [NUM_RULES-1:0] hitVec;
  logic [RG_PORTS-1:0]  portBit;
  logic                 portInRange;
  logic                 anyHit;
  logic [RG_IDX_W-1:0]  winIdx;
  logic                 winReject;
  logic                 nextAccept;
  logic                 fire;

  // Rule storage: one write port driven by the commit strobe.
  generate
    for (genvar r = 0; r < NUM_RULES; r++) begin : g_store
      always_ff @(posedge clk) begin
        if (!rstN) rules[r] <= '0;
        else if (strobe.commit && (32'(strobe.idx) == r)) rules[r] <= stage;
      end
    end
  endgenerate

  assign readRule = (32'(strobe.idx) < NUM_RULES) ? rules[strobe.idx] : '0;

  assign portInRange = (32'(reqPort) < RG_PORTS);
  assign portBit     = portInRange ? (RG_PORTS'(1) << reqPort) : '0;

  generate
    for (genvar r = 0; r < NUM_RULES; r++) begin : g_hit
      logic inPage, inId, inPort, inSec;
      assign inPage = (reqAddrHi >= rules[r].loPage) && (reqAddrHi <= rules[r].hiPage);
      assign inId   = (reqId >= rules[r].idLo) && (reqId <= rules[r].idHi);
      assign inPort = |(rules[r].portMask & portBit);
      assign inSec  = reqSecure ? rules[r].sec[0] : rules[r].sec[1];
      assign hitVec[r] = rules[r].valid && inPage && inId && inPort && inSec;
    end
  endgenerate

  // Lowest-numbered hit wins: scan from the top so lower indices overwrite.
  always_comb begin
    anyHit    = 1'b0;
    winIdx    = '0;
    for (int r = NUM_RULES - 1; r >= 0; r--) begin
      if (hitVec[r]) begin
        anyHit = 1'b1;
        winIdx = RG_IDX_W'(r);
      end
    end
    winReject = anyHit ? rules[winIdx].reject : 1'b0;
  end

  assign nextAccept = anyHit ? !winReject
                             : (portInRange && !(|(defMask & portBit)));

  assign reqReady = !vdValid || vdReady;
  assign fire     = reqValid && reqReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vdValid  <= 1'b0;
      vdAccept <= 1'b0;
      vdHit    <= 1'b0;
      vdRule   <= '0;
    end else if (fire) begin
      vdValid  <= 1'b1;
      vdAccept <= nextAccept;
      vdHit    <= anyHit;
      vdRule   <= winIdx;
    end else if (vdReady) begin
      vdValid  <= 1'b0;
    end
  end

  AST_VERDICT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (vdValid && !vdReady) |=> (vdValid && $stable({vdAccept, vdHit, vdRule}))); // R9
  AST_STALL_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    (vdValid && !vdReady) |-> !reqReady); // R9
  AST_RULE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (vdValid && vdHit) |-> (32'(vdRule) < NUM_RULES)); // R7
  AST_NOHIT_RULE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (vdValid && !vdHit) |-> (vdRule == '0)); // R9
  AST_COMMIT_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> (rules[$past(strobe.idx)] == $past(stage))); // R10
  AST_BAD_PORT_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (fire && !portInRange) |=> (!vdAccept && !vdHit)); // R8
endmodule

// File: rtl/regionGuard.sv
module regionGuard
  import rgPkg::*;
#(
  parameter int NUM_RULES = RG_RULES
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWe,
  input  logic [2:0]           regSel,
  input  logic [RG_BUS_W-1:0]  regWdata,
  output logic [RG_BUS_W-1:0]  regRdata,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic [RG_FIELD-1:0]  reqAddrHi,
  input  logic [RG_FIELD-1:0]  reqId,
  input  logic [RG_PORT_W-1:0] reqPort,
  input  logic                 reqSecure,
  output logic                 vdValid,
  input  logic                 vdReady,
  output logic                 vdAccept,
  output logic                 vdHit,
  output logic [RG_IDX_W-1:0]  vdRule
);
  rgStrobe_t           strobe;
  rgRule_t             stage;
  rgRule_t             readRule;
  logic [RG_PORTS-1:0] defMask;

  rgCtrl #(.NUM_RULES(NUM_RULES)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel),
    .regWdata(regWdata), .regRdata(regRdata), .readRule(readRule),
    .strobe(strobe), .stage(stage), .defMask(defMask)
  );

  rgMatch #(.NUM_RULES(NUM_RULES)) u_match (
    .clk(clk), .rstN(rstN), .strobe(strobe), .stage(stage),
    .defMask(defMask), .readRule(readRule),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddrHi(reqAddrHi),
    .reqId(reqId), .reqPort(reqPort), .reqSecure(reqSecure),
    .vdValid(vdValid), .vdReady(vdReady), .vdAccept(vdAccept),
    .vdHit(vdHit), .vdRule(vdRule)
  );
endmodule

// File: tb/regionGuard_bench.sv
module regionGuard_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regSel = 3'd0;
  logic [23:0] regWdata = '0;
  logic [23:0] regRdata;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [11:0] reqAddrHi = '0;
  logic [11:0] reqId = '0;
  logic [3:0]  reqPort = '0;
  logic        reqSecure = 1'b0;
  logic        vdValid;
  logic        vdReady = 1'b1;
  logic        vdAccept;
  logic        vdHit;
  logic [4:0]  vdRule;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  regionGuard u_regionGuard (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel),
    .regWdata(regWdata), .regRdata(regRdata),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddrHi(reqAddrHi),
    .reqId(reqId), .reqPort(reqPort), .reqSecure(reqSecure),
    .vdValid(vdValid), .vdReady(vdReady), .vdAccept(vdAccept),
    .vdHit(vdHit), .vdRule(vdRule)
  );

  // {page, id, port, secure, expAccept, expHit, expRule}
  localparam int NVEC = 12;
  localparam logic [35:0] VEC [NVEC] = '{
    {12'h000, 12'h000, 4'd0, 1'b1, 1'b1, 1'b1, 5'd0},  // R3 low edge of rule 0
    {12'h0FF, 12'hFFF, 4'd9, 1'b0, 1'b1, 1'b1, 5'd0},  // R3 inclusive top edge
    {12'h100, 12'h000, 4'd0, 1'b1, 1'b0, 1'b0, 5'd0},  // R8 no match -> default reject
    {12'h205, 12'h007, 4'd3, 1'b0, 1'b0, 1'b1, 5'd2},  // R7 lower rule 2 rejects
    {12'h250, 12'h007, 4'd3, 1'b0, 1'b1, 1'b1, 5'd3},  // R6 rule 3 accepts
    {12'h300, 12'h010, 4'd2, 1'b0, 1'b1, 1'b1, 5'd4},  // R4 low ID edge
    {12'h300, 12'h020, 4'd2, 1'b0, 1'b1, 1'b1, 5'd4},  // R4 high ID edge
    {12'h300, 12'h021, 4'd2, 1'b0, 1'b0, 1'b0, 5'd0},  // R4 ID above range
    {12'h300, 12'h00F, 4'd2, 1'b0, 1'b0, 1'b0, 5'd0},  // R4 ID below range
    {12'h300, 12'h010, 4'd3, 1'b0, 1'b0, 1'b0, 5'd0},  // R5 port not in mask
    {12'h300, 12'h010, 4'd2, 1'b1, 1'b0, 1'b0, 5'd0},  // R5 secure not admitted
    {12'h050, 12'h000, 4'd12, 1'b1, 1'b0, 1'b0, 5'd0}  // R8 port out of range
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [23:0] data);
    @(negedge clk);
    regWe = 1'b1; regSel = sel; regWdata = data;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [23:0] data);
    @(negedge clk);
    regSel = sel;
    #1 data = regRdata;
  endtask

  task automatic prog(input logic [4:0] idx, input logic [11:0] lo, input logic [11:0] hi,
                      input logic [11:0] idLo, input logic [11:0] idHi, input logic [1:0] sec,
                      input logic valid, input logic [9:0] mask, input logic rej);
    wr(3'd1, {hi, lo});
    wr(3'd2, {idHi, idLo});
    wr(3'd3, {10'd0, rej, mask, valid, sec});
    wr(3'd0, {17'd0, 2'b01, idx});
  endtask

  // Drives one request; on return the verdict is registered and visible.
  task automatic req(input logic [11:0] pg, input logic [11:0] id, input logic [3:0] port,
                     input logic sec);
    @(negedge clk);
    reqValid = 1'b1; reqAddrHi = pg; reqId = id; reqPort = port; reqSecure = sec;
    vdReady = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic expect_vd(input string req, input logic acc, input logic hit, input logic [4:0] rule);
    chk({req, " valid"}, 32'(vdValid), 32'd1);
    chk({req, " accept"}, 32'(vdAccept), 32'(acc));
    chk({req, " hit"}, 32'(vdHit), 32'(hit));
    chk({req, " rule"}, 32'(vdRule), 32'(rule));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [23:0] rdv;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk("R1 vdValid", 32'(vdValid), 0);
    rd(3'd0, rdv); chk("R1 cmd", 32'(rdv), 0);
    rd(3'd1, rdv); chk("R1 addr", 32'(rdv), 0);
    rd(3'd3, rdv); chk("R1 data", 32'(rdv), 0);
    rd(3'd4, rdv); chk("R1 default", 32'(rdv), 0);
    req(12'h400, 12'h001, 4'd1, 1'b0);
    expect_vd("R1 empty table", 1'b1, 1'b0, 5'd0);

    // R10 staged but not committed: index-only command write
    wr(3'd1, {12'h4FF, 12'h400});
    wr(3'd2, {12'hFFF, 12'h000});
    wr(3'd3, {10'd0, 1'b1, 10'h3FF, 1'b1, 2'b11});
    wr(3'd0, {17'd0, 2'b00, 5'd7});
    req(12'h400, 12'h001, 4'd1, 1'b0);
    expect_vd("R10 no commit", 1'b1, 1'b0, 5'd0);
    rd(3'd0, rdv); chk("R2 cmd index", 32'(rdv), 7);
    // R2 out-of-range index commit ignored
    wr(3'd0, {17'd0, 2'b01, 5'd25});
    req(12'h400, 12'h001, 4'd1, 1'b0);
    expect_vd("R2 bad index", 1'b1, 1'b0, 5'd0);

    prog(5'd0, 12'h000, 12'h0FF, 12'h000, 12'hFFF, 2'b11, 1'b1, 10'h3FF, 1'b0);
    prog(5'd2, 12'h200, 12'h20F, 12'h000, 12'hFFF, 2'b11, 1'b1, 10'h3FF, 1'b1);
    prog(5'd3, 12'h200, 12'h2FF, 12'h000, 12'hFFF, 2'b11, 1'b1, 10'h3FF, 1'b0);
    prog(5'd4, 12'h300, 12'h300, 12'h010, 12'h020, 2'b10, 1'b1, 10'h004, 1'b0);
    wr(3'd4, 24'h0003FF);

    for (int i = 0; i < NVEC; i++) begin
      req(VEC[i][35:24], VEC[i][23:12], VEC[i][11:8], VEC[i][7]);
      expect_vd($sformatf("R3-vector %0d", i), VEC[i][6], VEC[i][5], VEC[i][4:0]);
    end

    // R11 readback of rule 2
    wr(3'd0, {17'd0, 2'b10, 5'd2});
    rd(3'd1, rdv); chk("R11 addr", 32'(rdv), 32'h20F200);
    rd(3'd2, rdv); chk("R11 id", 32'(rdv), 32'hFFF000);
    rd(3'd3, rdv); chk("R11 data", 32'(rdv), 32'h3FFF);

    // R2 both bits: commit only (stage still holds rule 2 -> copy into rule 6)
    wr(3'd0, {17'd0, 2'b11, 5'd6});
    wr(3'd0, {17'd0, 2'b10, 5'd4});
    rd(3'd3, rdv); chk("R2 load rule 4", 32'(rdv), 32'h0026);
    wr(3'd0, {17'd0, 2'b10, 5'd6});
    rd(3'd1, rdv); chk("R2 commit wins", 32'(rdv), 32'h20F200);

    // R6 cleared rule never matches
    prog(5'd3, 12'h000, 12'h000, 12'h000, 12'h000, 2'b00, 1'b0, 10'h000, 1'b0);
    req(12'h250, 12'h007, 4'd3, 1'b0);
    expect_vd("R6 cleared", 1'b0, 1'b0, 5'd0);

    // R8 default bit 0 accepts on a port
    wr(3'd4, 24'h0003FB);
    req(12'h700, 12'h000, 4'd2, 1'b0);
    expect_vd("R8 default accept", 1'b1, 1'b0, 5'd0);

    // R10 commit visible in the very next cycle
    prog(5'd5, 12'h500, 12'h500, 12'h000, 12'hFFF, 2'b01, 1'b1, 10'h001, 1'b0);
    req(12'h500, 12'h000, 4'd0, 1'b1);
    expect_vd("R10 commit next cycle", 1'b1, 1'b1, 5'd5);

    // R9 stall holds verdict
    @(negedge clk);
    vdReady = 1'b0; reqValid = 1'b1;
    reqAddrHi = 12'h000; reqId = 12'h000; reqPort = 4'd0; reqSecure = 1'b1;
    @(negedge clk);
    reqAddrHi = 12'h205;
    chk("R9 not ready", 32'(reqReady), 0);
    @(negedge clk);
    expect_vd("R9 held", 1'b1, 1'b1, 5'd0);
    vdReady = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    expect_vd("R9 next", 1'b0, 1'b1, 5'd2);
    @(negedge clk);
    chk("R9 drained", 32'(vdValid), 0);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule